// File: doc/BRIEF.md
# Ethernet Frame Statistics Counter Bank

This block counts per-frame events for both directions of an Ethernet MAC. The receive and transmit datapaths each deliver a one-cycle end-of-frame report. A report carries the frame length in octets, whether the CRC was good, the destination address class and a pause-frame flag. Receive reports also carry drop, alignment-error and length-field-error flags. From each report the block updates a bank of 64-bit counters. The counters cover good frames, octets, unicast, multicast and broadcast frames, pause frames and error causes. They also cover the RMON size classes: seven length bins plus undersize, fragment, oversize and jabber.

The size classes are decided against a programmable maximum frame length, `cfg_max_len`. A value of zero selects the default of 1536 octets. Values above 16352 are limited to 16352. A received frame longer than the limit is treated as truncated to the limit.

Software reads the counters through a simple address/data port. Each counter takes two word addresses: the upper half first, then the lower half. Reading an upper half captures the matching lower half, so a pair of reads returns a coherent 64-bit value. A single clear input zeroes the whole bank.

Top module: `frame_stat_counters`

## Requirements
- R1: After reset, and in the cycle after `stat_clear` is high, every counter reads zero. Otherwise a counter never decreases.
- R2: Counter k has its upper word at address 2k and its lower word at 2k+1. The counter indices are: 0 rx good, 1 rx octets, 2/3/4 rx unicast/multicast/broadcast, 5 rx pause, 6 rx CRC error, 7 rx alignment error, 8 rx in-range length error, 9 rx too long, 10 rx drop, 11 undersize, 12 oversize, 13 jabber, 14 fragment, 15..21 length bins, 22 tx good, 23 tx octets, 24/25/26 tx unicast/multicast/broadcast, 27 tx pause, 28 tx error. `rd_data` is updated on the clock edge that samples `rd_en`. It holds while `rd_en` is low. It is zero for addresses 58 to 63.
- R3: A read of upper word 2k captures the lower half of counter k. The next read of address 2k+1 returns that captured half even if the counter changed in between. A later read of 2k+1 returns the live value.
- R4: A receive frame is good when all of these hold: the CRC is good, none of drop, alignment error or length error is set, and the length is between 64 and the limit. Only good frames update the good counter and the cast counters. The `rx_cast`/`tx_cast` encoding is 0 unicast, 1 multicast, 2 broadcast, 3 none.
- R5: Receive octets grow by the frame length, or by the limit when the frame is longer than the limit.
- R6: A frame whose length is from 64 to the limit increments exactly one bin, whatever its CRC status. The bins are: 64; 65-127; 128-255; 256-511; 512-1023; 1024-1518; 1519 up to the limit.
- R7: A frame shorter than 64 octets counts as undersize if its CRC is good and as a fragment otherwise.
- R8: A frame longer than the limit counts as too long. It also counts as oversize if its CRC is good and as jabber otherwise.
- R9: Receive CRC-error, alignment-error and drop counters follow their flags on every report. The length-error counter follows its flag only when the length is within the limit.
- R10: A pause frame with good CRC increments the pause counter of its direction.
- R11: A transmit report increments tx octets by its length. With a good CRC it also increments tx good and its cast counter. With a bad CRC it increments tx error.
- R12: The limit is 1536 when `cfg_max_len` is 0, 16352 when it exceeds 16352, and `cfg_max_len` otherwise.
- R13: When `stat_clear` and a frame report occur in the same cycle, every counter is zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_eof | input | 1 | Receive end-of-frame report valid |
| rx_len | input | 14 | Receive frame length in octets |
| rx_crc_ok | input | 1 | Receive CRC good |
| rx_cast | input | 2 | Receive address class |
| rx_pause | input | 1 | Receive pause frame |
| rx_drop | input | 1 | Receive frame dropped |
| rx_align_err | input | 1 | Receive alignment error |
| rx_len_err | input | 1 | Receive length field mismatch |
| tx_eof | input | 1 | Transmit end-of-frame report valid |
| tx_len | input | 14 | Transmit frame length in octets |
| tx_crc_ok | input | 1 | Transmit frame without error |
| tx_cast | input | 2 | Transmit address class |
| tx_pause | input | 1 | Transmit pause frame |
| cfg_max_len | input | 14 | Maximum frame length setting |
| stat_clear | input | 1 | Zero all counters |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 6 | Word address |
| rd_data | output | 32 | Read data |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a clear and a frame report: the bench raises `stat_clear` together with `rx_eof` and expects every counter to read zero afterwards. The second pair is a captured lower word and a counter update: the bench reads an upper word, lets a frame change the same counter, and expects the following lower-word read to return the value from before the frame. Random traffic also places receive and transmit reports in the same cycle. Every counter is then compared with a bench model.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
    localparam int LEN_W     = 14;
    localparam int CNT_W     = 64;
    localparam int WORD_W    = 32;
    localparam int N_CNT     = 29;
    localparam int IDX_W     = $clog2(N_CNT);
    localparam int ADDR_W    = IDX_W + 1;
    localparam int N_BKT     = 7;
    localparam int MIN_FRAME = 64;

    localparam int C_RX_GOOD  = 0;
    localparam int C_RX_OCT   = 1;
    localparam int C_RX_UC    = 2;
    localparam int C_RX_MC    = 3;
    localparam int C_RX_BC    = 4;
    localparam int C_RX_PAUSE = 5;
    localparam int C_RX_FCS   = 6;
    localparam int C_RX_ALIGN = 7;
    localparam int C_RX_LERR  = 8;
    localparam int C_RX_LONG  = 9;
    localparam int C_RX_DROP  = 10;
    localparam int C_RX_UNDER = 11;
    localparam int C_RX_OVER  = 12;
    localparam int C_RX_JAB   = 13;
    localparam int C_RX_FRAG  = 14;
    localparam int C_RX_BKT0  = 15;
    localparam int C_TX_GOOD  = 22;
    localparam int C_TX_OCT   = 23;
    localparam int C_TX_UC    = 24;
    localparam int C_TX_MC    = 25;
    localparam int C_TX_BC    = 26;
    localparam int C_TX_PAUSE = 27;
    localparam int C_TX_ERR   = 28;

    // upper edge of each length bin except the open last one
    localparam int BKT_TOP [N_BKT-1] = '{64, 127, 255, 511, 1023, 1518};

    typedef enum logic [1:0] {
        CAST_UNI   = 2'd0,
        CAST_MULTI = 2'd1,
        CAST_BROAD = 2'd2,
        CAST_NONE  = 2'd3
    } cast_e;

    typedef struct packed {
        logic             valid;
        logic [LEN_W-1:0] len;
        logic             crc_ok;
        cast_e            cast;
        logic             pause;
        logic             drop;
        logic             align_err;
        logic             len_err;
    } frame_rpt_t;

    typedef logic [N_CNT-1:0][LEN_W-1:0] add_vec_t;
    typedef logic [N_CNT-1:0][CNT_W-1:0] cnt_vec_t;

    function automatic logic [LEN_W-1:0] eff_max_len(
        input logic [LEN_W-1:0] cfg,
        input logic [LEN_W-1:0] dflt,
        input logic [LEN_W-1:0] cap);
        logic [LEN_W-1:0] r;
        if (cfg == '0)      r = dflt;
        else if (cfg > cap) r = cap;
        else                r = cfg;
        return r;
    endfunction

    // bin number for a length already known to be >= MIN_FRAME
    function automatic int unsigned bucket_of(input logic [LEN_W-1:0] len);
        int unsigned b;
        logic        found;
        b     = N_BKT - 1;
        found = 1'b0;
        for (int i = 0; i < N_BKT - 1; i++) begin
            if (!found && int'(len) <= BKT_TOP[i]) begin
                b     = i;
                found = 1'b1;
            end
        end
        return b;
    endfunction
endpackage

// File: rtl/fsc_classify.sv
module fsc_classify
    import fsc_pkg::*;
#(
    parameter bit IS_RX = 1'b1
) (
    input  frame_rpt_t       rpt,
    input  logic [LEN_W-1:0] max_len,
    output add_vec_t         add
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    generate
        if (IS_RX) begin : g_rx
            logic        short_f, long_f, fits, good;
            int unsigned bkt;
            always_comb begin
                add     = '0;
                short_f = rpt.len < LEN_W'(MIN_FRAME);
                long_f  = rpt.len > max_len;
                fits    = !short_f && !long_f;
                good    = rpt.crc_ok && !rpt.align_err && !rpt.len_err
                          && !rpt.drop && fits;
                bkt     = bucket_of(rpt.len);
                if (rpt.valid) begin
                    add[C_RX_OCT]   = long_f ? max_len : rpt.len;
                    add[C_RX_GOOD]  = good ? ONE : '0;
                    add[C_RX_UC]    = (good && rpt.cast == CAST_UNI)   ? ONE : '0;
                    add[C_RX_MC]    = (good && rpt.cast == CAST_MULTI) ? ONE : '0;
                    add[C_RX_BC]    = (good && rpt.cast == CAST_BROAD) ? ONE : '0;
                    add[C_RX_PAUSE] = (rpt.pause && rpt.crc_ok) ? ONE : '0;
                    add[C_RX_FCS]   = !rpt.crc_ok ? ONE : '0;
                    add[C_RX_ALIGN] = rpt.align_err ? ONE : '0;
                    add[C_RX_LERR]  = (rpt.len_err && !long_f) ? ONE : '0;
                    add[C_RX_LONG]  = long_f ? ONE : '0;
                    add[C_RX_DROP]  = rpt.drop ? ONE : '0;
                    add[C_RX_UNDER] = (short_f && rpt.crc_ok)  ? ONE : '0;
                    add[C_RX_FRAG]  = (short_f && !rpt.crc_ok) ? ONE : '0;
                    add[C_RX_OVER]  = (long_f && rpt.crc_ok)   ? ONE : '0;
                    add[C_RX_JAB]   = (long_f && !rpt.crc_ok)  ? ONE : '0;
                    for (int b = 0; b < N_BKT; b++)
                        add[C_RX_BKT0 + b] = (fits && bkt == b) ? ONE : '0;
                end
            end
        end else begin : g_tx
            always_comb begin
                add = '0;
                if (rpt.valid) begin
                    add[C_TX_OCT]   = rpt.len;
                    add[C_TX_GOOD]  = rpt.crc_ok ? ONE : '0;
                    add[C_TX_ERR]   = !rpt.crc_ok ? ONE : '0;
                    add[C_TX_UC]    = (rpt.crc_ok && rpt.cast == CAST_UNI)   ? ONE : '0;
                    add[C_TX_MC]    = (rpt.crc_ok && rpt.cast == CAST_MULTI) ? ONE : '0;
                    add[C_TX_BC]    = (rpt.crc_ok && rpt.cast == CAST_BROAD) ? ONE : '0;
                    add[C_TX_PAUSE] = (rpt.crc_ok && rpt.pause) ? ONE : '0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/fsc_counter_bank.sv
module fsc_counter_bank
    import fsc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  add_vec_t add,
    output cnt_vec_t cnt
);
    generate
        for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
            logic [CNT_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst || clear) q <= '0;
                else              q <= q + CNT_W'(add[i]);
            end
            assign cnt[i] = q;
        end
    endgenerate
endmodule

// File: rtl/fsc_read_port.sv
module fsc_read_port
    import fsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  cnt_vec_t          cnt,
    output logic [WORD_W-1:0] rd_data
);
    localparam int HI = CNT_W - 1;

    logic [IDX_W-1:0]  idx;
    logic              lo_sel, in_map;
    logic [WORD_W-1:0] snap_q;
    logic [IDX_W-1:0]  snap_idx_q;
    logic              snap_vld_q;
    logic [CNT_W-1:0]  sel;

    assign idx    = rd_addr[ADDR_W-1:1];
    assign lo_sel = rd_addr[0];
    assign in_map = rd_addr < ADDR_W'(2 * N_CNT);
    assign sel    = in_map ? cnt[idx] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data    <= '0;
            snap_q     <= '0;
            snap_idx_q <= '0;
            snap_vld_q <= 1'b0;
        end else begin
            if (rd_en) begin
                if (!in_map) begin
                    rd_data <= '0;
                end else if (!lo_sel) begin
                    rd_data    <= sel[HI -: WORD_W];
                    snap_q     <= sel[WORD_W-1:0];
                    snap_idx_q <= idx;
                    snap_vld_q <= 1'b1;
                end else if (snap_vld_q && snap_idx_q == idx) begin
                    rd_data    <= snap_q;
                    snap_vld_q <= 1'b0;
                end else begin
                    rd_data <= sel[WORD_W-1:0];
                end
            end
            if (clear) snap_vld_q <= 1'b0;
        end
    end
endmodule

// File: rtl/frame_stat_counters.sv
module frame_stat_counters
    import fsc_pkg::*;
#(
    parameter int DEF_MAX_LEN = 1536,
    parameter int CAP_MAX_LEN = 16352
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_eof,
    input  logic [13:0]       rx_len,
    input  logic              rx_crc_ok,
    input  logic [1:0]        rx_cast,
    input  logic              rx_pause,
    input  logic              rx_drop,
    input  logic              rx_align_err,
    input  logic              rx_len_err,
    input  logic              tx_eof,
    input  logic [13:0]       tx_len,
    input  logic              tx_crc_ok,
    input  logic [1:0]        tx_cast,
    input  logic              tx_pause,
    input  logic [13:0]       cfg_max_len,
    input  logic              stat_clear,
    input  logic              rd_en,
    input  logic [5:0]        rd_addr,
    output logic [31:0]       rd_data
);
    frame_rpt_t       rx_rpt, tx_rpt;
    logic [LEN_W-1:0] max_eff;
    add_vec_t         add_rx, add_tx, add_all;
    cnt_vec_t         cnt_all;

    assign max_eff = eff_max_len(cfg_max_len, LEN_W'(DEF_MAX_LEN), LEN_W'(CAP_MAX_LEN));

    always_comb begin
        rx_rpt = '{valid: rx_eof, len: rx_len, crc_ok: rx_crc_ok,
                   cast: cast_e'(rx_cast), pause: rx_pause, drop: rx_drop,
                   align_err: rx_align_err, len_err: rx_len_err};
        tx_rpt = '{valid: tx_eof, len: tx_len, crc_ok: tx_crc_ok,
                   cast: cast_e'(tx_cast), pause: tx_pause, drop: 1'b0,
                   align_err: 1'b0, len_err: 1'b0};
    end

    fsc_classify #(.IS_RX(1'b1)) u_rx_cls (.rpt(rx_rpt), .max_len(max_eff), .add(add_rx));
    fsc_classify #(.IS_RX(1'b0)) u_tx_cls (.rpt(tx_rpt), .max_len(max_eff), .add(add_tx));

    // the two classifiers fill disjoint counter slots
    assign add_all = add_rx | add_tx;

    fsc_counter_bank u_bank (
        .clk(clk), .rst(rst), .clear(stat_clear), .add(add_all), .cnt(cnt_all)
    );

    fsc_read_port u_rd (
        .clk(clk), .rst(rst), .clear(stat_clear), .rd_en(rd_en),
        .rd_addr(rd_addr), .cnt(cnt_all), .rd_data(rd_data)
    );
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker
    import fsc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        stat_clear,
    input logic        rx_eof,
    input logic        rd_en,
    input logic [5:0]  rd_addr,
    input logic [31:0] rd_data,
    input cnt_vec_t    cnt_all,
    input add_vec_t    add_all
);
    logic [3:0]       size_cls;
    logic [N_BKT-1:0] bkt_hit;
    logic             rx_any;

    always_comb begin
        size_cls = {|add_all[C_RX_UNDER], |add_all[C_RX_FRAG],
                    |add_all[C_RX_OVER],  |add_all[C_RX_JAB]};
        for (int b = 0; b < N_BKT; b++) bkt_hit[b] = |add_all[C_RX_BKT0 + b];
        rx_any = 1'b0;
        for (int i = 0; i <= C_RX_BKT0 + N_BKT - 1; i++) rx_any = rx_any | (|add_all[i]);
    end

    // R1: clear empties the bank on the next edge
    p_clear_zero_r1: assert property (@(posedge clk) disable iff (rst)
        stat_clear |=> (cnt_all == '0));

    // R13: clear beats a simultaneous receive report
    p_clear_wins_r13: assert property (@(posedge clk) disable iff (rst)
        (stat_clear && rx_eof) |=> (cnt_all == '0));

    generate
        for (genvar i = 0; i < N_CNT; i++) begin : g_mono
            // R1: only clear can lower a counter
            p_no_decrease_r1: assert property (@(posedge clk) disable iff (rst)
                !stat_clear |=> (cnt_all[i] >= $past(cnt_all[i])));
        end
    endgenerate

    // R2: read data holds without a strobe
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R2: unmapped addresses read zero
    p_unmapped_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr >= 6'(2 * N_CNT)) |=> (rd_data == '0));

    // R7 and R8: at most one size class per frame
    p_one_class_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(size_cls));

    // R6: at most one length bin per frame
    p_one_bin_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bkt_hit));

    // R4: no receive counter moves without a report
    p_rx_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !rx_eof |-> !rx_any);
endmodule

bind frame_stat_counters fsc_checker u_chk (
    .clk(clk), .rst(rst), .stat_clear(stat_clear), .rx_eof(rx_eof),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .cnt_all(cnt_all), .add_all(add_all)
);

// File: tb/tb_frame_stat_counters.sv
module tb_frame_stat_counters;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_eof = 0, rx_crc_ok = 0, rx_pause = 0, rx_drop = 0;
    logic        rx_align_err = 0, rx_len_err = 0;
    logic [13:0] rx_len = 0;
    logic [1:0]  rx_cast = 0;
    logic        tx_eof = 0, tx_crc_ok = 0, tx_pause = 0;
    logic [13:0] tx_len = 0;
    logic [1:0]  tx_cast = 0;
    logic [13:0] cfg_max_len = 0;
    logic        stat_clear = 0;
    logic        rd_en = 0;
    logic [5:0]  rd_addr = 0;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] expv [0:28];

    always #2 clk = ~clk;

    frame_stat_counters dut (.*);

    function automatic int bmax(int cfg);
        if (cfg == 0) return 1536;
        if (cfg > 16352) return 16352;
        return cfg;
    endfunction

    function automatic string req_of(int k);
        if (k == 1) return "R5";
        if (k == 0 || (k >= 2 && k <= 4)) return "R4";
        if (k == 5 || k == 27) return "R10";
        if (k == 9 || k == 12 || k == 13) return "R8";
        if (k == 11 || k == 14) return "R7";
        if (k >= 6 && k <= 10) return "R9";
        if (k >= 15 && k <= 21) return "R6";
        return "R11";
    endfunction

    task automatic chk(input logic [63:0] got, input logic [63:0] exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic model_rx();
        int m, len, b;
        bit good;
        m = bmax(int'(cfg_max_len));
        len = int'(rx_len);
        if (len < 64) begin
            if (rx_crc_ok) expv[11]++; else expv[14]++;
        end else if (len > m) begin
            expv[9]++;
            if (rx_crc_ok) expv[12]++; else expv[13]++;
        end else begin
            b = (len == 64) ? 0 : (len < 128) ? 1 : (len < 256) ? 2 :
                (len < 512) ? 3 : (len < 1024) ? 4 : (len < 1519) ? 5 : 6;
            expv[15 + b]++;
        end
        expv[1] += 64'((len > m) ? m : len);
        if (!rx_crc_ok) expv[6]++;
        if (rx_align_err) expv[7]++;
        if (rx_len_err && len <= m) expv[8]++;
        if (rx_drop) expv[10]++;
        if (rx_pause && rx_crc_ok) expv[5]++;
        good = rx_crc_ok && !rx_align_err && !rx_len_err && !rx_drop && len >= 64 && len <= m;
        if (good) begin
            expv[0]++;
            if (rx_cast < 3) expv[2 + int'(rx_cast)]++;
        end
    endtask

    task automatic model_tx();
        expv[23] += 64'(tx_len);
        if (tx_crc_ok) begin
            expv[22]++;
            if (tx_cast < 3) expv[24 + int'(tx_cast)]++;
            if (tx_pause) expv[27]++;
        end else expv[28]++;
    endtask

    // one clock with whatever was driven; model follows the same edge
    task automatic tick();
        @(posedge clk);
        if (stat_clear) begin
            for (int k = 0; k < 29; k++) expv[k] = '0;
        end else begin
            if (rx_eof) model_rx();
            if (tx_eof) model_tx();
        end
        @(negedge clk);
        rx_eof = 0; tx_eof = 0; stat_clear = 0;
    endtask

    task automatic set_rx(int len, bit crc, int cast, bit pause, bit drop, bit al, bit le);
        rx_eof = 1; rx_len = 14'(len); rx_crc_ok = crc; rx_cast = 2'(cast);
        rx_pause = pause; rx_drop = drop; rx_align_err = al; rx_len_err = le;
    endtask

    task automatic set_tx(int len, bit crc, int cast, bit pause);
        tx_eof = 1; tx_len = 14'(len); tx_crc_ok = crc; tx_cast = 2'(cast); tx_pause = pause;
    endtask

    task automatic rd_word(input int addr, output logic [31:0] v);
        rd_en = 1; rd_addr = 6'(addr);
        @(posedge clk);
        @(negedge clk);
        v = rd_data;
        rd_en = 0;
    endtask

    task automatic rd64(input int k, output logic [63:0] v);
        logic [31:0] hi, lo;
        rd_word(2 * k, hi);
        rd_word(2 * k + 1, lo);
        v = {hi, lo};
    endtask

    task automatic check_all(input string force_req);
        logic [63:0] v;
        for (int k = 0; k < 29; k++) begin
            rd64(k, v);
            chk(v, expv[k], (force_req != "") ? force_req : req_of(k));
        end
    endtask

    function automatic int gen_len(int m);
        int r, v;
        r = int'($urandom % 16);
        case (r)
            0: v = int'($urandom % 64);
            1: v = 64;   2: v = 65;   3: v = 127;  4: v = 128;
            5: v = 255;  6: v = 256;  7: v = 511;  8: v = 1023;
            9: v = 1024; 10: v = 1518; 11: v = 1519;
            12: v = m;   13: v = m + 1;
            default: v = 64 + int'($urandom % 2000);
        endcase
        return v & 16383;
    endfunction

    initial begin
        logic [31:0] w, w_old, w_hold;
        logic [63:0] v;
        int cfgs [5];
        cfgs = '{0, 1518, 2000, 9000, 16383};
        void'($urandom(32'd20240611));
        for (int k = 0; k < 29; k++) expv[k] = '0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1: state after reset
        check_all("R1");

        // directed frames with default limit (R12 via cfg 0)
        cfg_max_len = 0;
        set_rx(64, 1, 0, 0, 0, 0, 0); tick();
        set_rx(65, 1, 1, 0, 0, 0, 0); set_tx(300, 1, 2, 0); tick();
        set_rx(127, 1, 2, 0, 0, 0, 0); tick();
        set_rx(128, 0, 0, 0, 0, 0, 0); set_tx(70, 0, 0, 0); tick();
        set_rx(1518, 1, 0, 0, 0, 0, 0); tick();
        set_rx(1519, 1, 0, 0, 0, 0, 0); tick();
        set_rx(1536, 1, 1, 0, 0, 0, 0); tick();
        set_rx(1537, 1, 0, 0, 0, 0, 0); tick();
        set_rx(1600, 0, 0, 0, 0, 0, 0); tick();
        set_rx(63, 1, 0, 0, 0, 0, 0); tick();
        set_rx(10, 0, 0, 0, 0, 0, 0); tick();
        set_rx(64, 1, 1, 1, 0, 0, 0); set_tx(64, 1, 1, 1); tick();
        set_rx(200, 1, 0, 0, 1, 0, 0); tick();
        set_rx(200, 1, 0, 0, 0, 1, 0); tick();
        set_rx(200, 1, 0, 0, 0, 0, 1); tick();
        set_rx(3000, 1, 0, 0, 0, 0, 1); tick();
        check_all("");
        // literal expectations for the directed set
        rd64(13, v); chk(v, 64'd1, "R8 jabber");
        rd64(21, v); chk(v, 64'd2, "R6 top bin");
        rd64(8, v);  chk(v, 64'd1, "R9 length error in range only");

        // R2: hold while idle, unmapped reads
        rd_word(0, w_hold);
        @(negedge clk);
        chk(64'(rd_data), 64'(w_hold), "R2 hold");
        rd_word(58, w); chk(64'(w), 64'd0, "R2 unmapped 58");
        rd_word(63, w); chk(64'(w), 64'd0, "R2 unmapped 63");

        // R3: capture survives an update between the halves
        rd_word(2, w); chk(64'(w), 64'(expv[1][63:32]), "R2 upper word");
        w_old = expv[1][31:0];
        set_rx(100, 1, 0, 0, 0, 0, 0); tick();
        rd_word(3, w); chk(64'(w), 64'(w_old), "R3 captured lower");
        rd_word(3, w); chk(64'(w), 64'(expv[1][31:0]), "R3 live lower");

        // R13: clear and report together
        set_rx(64, 1, 0, 0, 0, 0, 0); set_tx(64, 1, 0, 0); stat_clear = 1; tick();
        check_all("R13");

        // R12: limit above cap is held at 16352, then back to default
        cfg_max_len = 14'd16383;
        set_rx(16352, 1, 0, 0, 0, 0, 0); tick();
        set_rx(16353, 1, 0, 0, 0, 0, 0); tick();
        rd64(21, v); chk(v, 64'd1, "R12 cap bin");
        rd64(12, v); chk(v, 64'd1, "R12 cap oversize");
        rd64(1, v);  chk(v, 64'd32704, "R12 cap octets");
        cfg_max_len = 14'd0;
        set_rx(1536, 1, 0, 0, 0, 0, 0); tick();
        set_rx(1537, 1, 0, 0, 0, 0, 0); tick();
        rd64(21, v); chk(v, 64'd2, "R12 default bin");
        rd64(12, v); chk(v, 64'd2, "R12 default oversize");
        rd64(1, v);  chk(v, 64'd35776, "R12 default octets");
        cfg_max_len = 14'd2000;
        set_rx(1900, 1, 0, 0, 0, 0, 0); tick();
        rd64(21, v); chk(v, 64'd3, "R12 programmed limit");

        // random traffic, both directions, changing limits
        for (int n = 0; n < 4000; n++) begin
            int m;
            if ($urandom % 200 == 0) cfg_max_len = 14'(cfgs[$urandom % 5]);
            m = bmax(int'(cfg_max_len));
            if ($urandom % 4 != 0)
                set_rx(gen_len(m), ($urandom % 5) != 0, int'($urandom % 4),
                       ($urandom % 8) == 0, ($urandom % 16) == 0,
                       ($urandom % 16) == 0, ($urandom % 16) == 0);
            if ($urandom % 3 != 0)
                set_tx(gen_len(m), ($urandom % 6) != 0, int'($urandom % 4),
                       ($urandom % 8) == 0);
            tick();
        end
        check_all("");

        // R1: clear empties everything
        stat_clear = 1; tick();
        check_all("R1");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule